// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block builds the interrupt outputs of a serial port from the fill counts of its receive and transmit FIFOs and from single-cycle event pulses. The events are receive errors, the receive timeout and modem line changes. A level register holds one 3-bit fractional threshold code for each direction. Each raw status bit is sticky: it latches when its condition is seen and holds until software writes a one to that bit through the clear port.

A mask register selects which raw bits reach the outputs. The masked vector gives one interrupt line per source. A single combined line, the OR of all masked bits, is registered. The FIFOs, the timeout counter and modem edge detection sit outside this block. Only their results enter here, as fill counts and pulses.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, the level register, mask register, raw status and combined interrupt are all zero. With both fills at zero, the first clock after reset sets only the transmit raw bit (raw = 0x020).
- R2: A write with wr_sel = 0 loads the level register from wr_data[5:0]. The transmit code is in bits 2:0 and the receive code is in bits 5:3. Codes 0, 1, 2, 3 and 4 select 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH, and codes 5 to 7 also select 7/8. With DEPTH 16 the thresholds are 2, 4, 8, 12 and 14.
- R3: Raw bit 4 (receive) sets on any clock where rx_fill is at or above the receive threshold, and not when it is one below.
- R4: Raw bit 5 (transmit) sets on any clock where tx_fill is at or below the transmit threshold, and not when it is one above.
- R5: Each event pulse latches its own raw bit and no other. Modem events 3:0 map to bits 3:0, timeout to bit 6, framing to bit 7, parity to bit 8, break to bit 9 and overrun to bit 10.
- R6: A raw bit stays set after its condition goes away, until it is cleared.
- R7: A write with wr_sel = 2 clears each raw bit whose wr_data bit is 1 and leaves the other raw bits unchanged.
- R8: When a set condition and a clear of the same bit fall in the same clock, the bit ends up set.
- R9: A write with wr_sel = 1 loads the mask from wr_data[10:0]. irq_masked equals the raw status ANDed with the mask.
- R10: irq_any is the OR of irq_masked, delayed by one clock.
- R11: Writing the mask does not change the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 level, 1 mask, 2 clear, 3 none |
| wr_data | input | 16 | Write data |
| rx_fill | input | CNT_W | Receive FIFO fill count |
| tx_fill | input | CNT_W | Transmit FIFO fill count |
| modem_evt | input | 4 | Modem change pulses (ring, CTS, DCD, DSR) |
| rto_pulse | input | 1 | Receive timeout pulse |
| fe_pulse | input | 1 | Framing error pulse |
| pe_pulse | input | 1 | Parity error pulse |
| be_pulse | input | 1 | Break pulse |
| oe_pulse | input | 1 | Overrun pulse |
| cfg_level | output | 6 | Level register contents |
| cfg_mask | output | 11 | Mask register contents |
| stat_raw | output | 11 | Raw status |
| irq_masked | output | 11 | Masked interrupt lines |
| irq_any | output | 1 | Registered combined interrupt |

## Verification
Two functions can act on the same raw bit in one clock: a fresh set and a software clear. The bench raises the framing pulse in the same clock as a clear write that targets bit 7. It then expects bit 7 to stay set while bit 8 remains untouched. A second run clears bit 7 with no pulse present, to show the clear works on its own. The receive and transmit thresholds have a second collision: a clear write lands while the fill sits one step short of the threshold. The bit must read zero afterwards and must set on the next clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NUM_IRQ = 11;

    localparam int BIT_RX  = 4;
    localparam int BIT_TX  = 5;
    localparam int BIT_RTO = 6;
    localparam int BIT_FE  = 7;
    localparam int BIT_PE  = 8;
    localparam int BIT_BE  = 9;
    localparam int BIT_OE  = 10;

    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CLEAR = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [2:0]         rx_code;
        logic [2:0]         tx_code;
        logic [NUM_IRQ-1:0] mask;
    } cfg_t;

endpackage

// File: rtl/uirq_cfg.sv
module uirq_cfg
    import uirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output cfg_t        cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_LEVEL: begin
                    cfg_d.tx_code = wr_data[2:0];
                    cfg_d.rx_code = wr_data[5:3];
                end
                SEL_MASK: cfg_d.mask = wr_data[NUM_IRQ-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter bit IS_RX  = 1'b1
) (
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] fill,
    output logic             hit
);

    localparam int EIGHTH = DEPTH / 8;
    localparam logic [CNT_W-1:0] T_1_8 = CNT_W'(EIGHTH);
    localparam logic [CNT_W-1:0] T_1_4 = CNT_W'(2 * EIGHTH);
    localparam logic [CNT_W-1:0] T_1_2 = CNT_W'(4 * EIGHTH);
    localparam logic [CNT_W-1:0] T_3_4 = CNT_W'(6 * EIGHTH);
    localparam logic [CNT_W-1:0] T_7_8 = CNT_W'(7 * EIGHTH);

    logic [CNT_W-1:0] thr;

    always_comb begin
        case (code)
            3'd0:    thr = T_1_8;
            3'd1:    thr = T_1_4;
            3'd2:    thr = T_1_2;
            3'd3:    thr = T_3_4;
            default: thr = T_7_8;
        endcase
    end

    generate
        if (IS_RX) begin : g_rx
            assign hit = (fill >= thr);
        end else begin : g_tx
            assign hit = (fill <= thr);
        end
    endgenerate

endmodule

// File: rtl/uirq_raw.sv
module uirq_raw
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    output logic [NUM_IRQ-1:0] raw
);

    logic [NUM_IRQ-1:0] raw_d, raw_q;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
            always_comb begin
                raw_d[i] = raw_q[i];
                if (clr_vec[i]) raw_d[i] = 1'b0;
                if (set_vec[i]) raw_d[i] = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw = raw_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [15:0]        wr_data,
    input  logic [CNT_W-1:0]   rx_fill,
    input  logic [CNT_W-1:0]   tx_fill,
    input  logic [3:0]         modem_evt,
    input  logic               rto_pulse,
    input  logic               fe_pulse,
    input  logic               pe_pulse,
    input  logic               be_pulse,
    input  logic               oe_pulse,
    output logic [5:0]         cfg_level,
    output logic [NUM_IRQ-1:0] cfg_mask,
    output logic [NUM_IRQ-1:0] stat_raw,
    output logic [NUM_IRQ-1:0] irq_masked,
    output logic               irq_any
);

    cfg_t               cfg;
    logic               rx_hit, tx_hit;
    logic [NUM_IRQ-1:0] set_vec, clr_vec;

    typedef struct packed {
        logic any;
    } top_st_t;

    top_st_t st_d, st_q;

    uirq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    uirq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b1)) u_rx_cmp (
        .code (cfg.rx_code),
        .fill (rx_fill),
        .hit  (rx_hit)
    );

    uirq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b0)) u_tx_cmp (
        .code (cfg.tx_code),
        .fill (tx_fill),
        .hit  (tx_hit)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[3:0]     = modem_evt;
        set_vec[BIT_RX]  = rx_hit;
        set_vec[BIT_TX]  = tx_hit;
        set_vec[BIT_RTO] = rto_pulse;
        set_vec[BIT_FE]  = fe_pulse;
        set_vec[BIT_PE]  = pe_pulse;
        set_vec[BIT_BE]  = be_pulse;
        set_vec[BIT_OE]  = oe_pulse;
        clr_vec = (wr_en && wr_sel == SEL_CLEAR) ? wr_data[NUM_IRQ-1:0] : '0;
    end

    uirq_raw u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .raw     (stat_raw)
    );

    assign irq_masked = stat_raw & cfg.mask;

    always_comb begin
        st_d.any = |irq_masked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_any   = st_q.any;
    assign cfg_level = {cfg.rx_code, cfg.tx_code};
    assign cfg_mask  = cfg.mask;

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
    import uirq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [15:0]        wr_data,
    input logic [CNT_W-1:0]   rx_fill,
    input logic [CNT_W-1:0]   tx_fill,
    input logic               rto_pulse,
    input logic               fe_pulse,
    input logic               pe_pulse,
    input logic               be_pulse,
    input logic               oe_pulse,
    input logic [NUM_IRQ-1:0] stat_raw,
    input logic [NUM_IRQ-1:0] irq_masked,
    input logic               irq_any
);

    logic clr_w;
    assign clr_w = wr_en && (wr_sel == SEL_CLEAR);

    a_r3_rx_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill >= CNT_W'(DEPTH)) |=> stat_raw[BIT_RX]);

    a_r4_tx_empty_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fill == '0) |=> stat_raw[BIT_TX]);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_pulse && clr_w && wr_data[BIT_FE]) |=> stat_raw[BIT_FE]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_w |=> ((stat_raw & $past(stat_raw)) == $past(stat_raw)));

    a_r7_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !rto_pulse && !fe_pulse && !pe_pulse && !be_pulse && !oe_pulse)
        |=> ((stat_raw[10:6] & $past(wr_data[10:6])) == 5'd0));

    a_r10_any_lags: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_any == $past(|irq_masked)));

endmodule

bind uart_irq_ctrl uirq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rx_fill    (rx_fill),
    .tx_fill    (tx_fill),
    .rto_pulse  (rto_pulse),
    .fe_pulse   (fe_pulse),
    .pe_pulse   (pe_pulse),
    .be_pulse   (be_pulse),
    .oe_pulse   (oe_pulse),
    .stat_raw   (stat_raw),
    .irq_masked (irq_masked),
    .irq_any    (irq_any)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;

    localparam int DEPTH = 16;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd3;
    logic [15:0]      wr_data = '0;
    logic [CNT_W-1:0] rx_fill = '0;
    logic [CNT_W-1:0] tx_fill = '0;
    logic [3:0]       modem_evt = '0;
    logic             rto_pulse = 1'b0;
    logic             fe_pulse = 1'b0;
    logic             pe_pulse = 1'b0;
    logic             be_pulse = 1'b0;
    logic             oe_pulse = 1'b0;
    logic [5:0]       cfg_level;
    logic [10:0]      cfg_mask, stat_raw, irq_masked;
    logic             irq_any;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_fill(rx_fill), .tx_fill(tx_fill), .modem_evt(modem_evt),
        .rto_pulse(rto_pulse), .fe_pulse(fe_pulse), .pe_pulse(pe_pulse),
        .be_pulse(be_pulse), .oe_pulse(oe_pulse), .cfg_level(cfg_level),
        .cfg_mask(cfg_mask), .stat_raw(stat_raw), .irq_masked(irq_masked),
        .irq_any(irq_any)
    );

    function automatic int exp_thr(int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic drive_evt(int idx, logic v);
        case (idx)
            0, 1, 2, 3: modem_evt[idx] = v;
            6:  rto_pulse = v;
            7:  fe_pulse  = v;
            8:  pe_pulse  = v;
            9:  be_pulse  = v;
            10: oe_pulse  = v;
            default: ;
        endcase
    endtask

    task automatic t_reset();
        step();
        chk("R1 raw in reset", 32'(stat_raw), 0);
        chk("R1 mask in reset", 32'(cfg_mask), 0);
        chk("R1 level in reset", 32'(cfg_level), 0);
        chk("R1 any in reset", 32'(irq_any), 0);
        rst_n = 1'b1;
        step();
        chk("R1 first raw after reset", 32'(stat_raw), 32'h020);
        tx_fill = 5'd16;
        wr(2'd2, 16'h07FF);
        chk("R7 clear all", 32'(stat_raw), 0);
    endtask

    task automatic t_rx_levels();
        for (int c = 0; c < 8; c++) begin
            int thr = exp_thr(c);
            wr(2'd0, 16'(c << 3));
            chk("R2 level rx field", 32'(cfg_level), 32'(c << 3));
            rx_fill = CNT_W'(thr - 1);
            wr(2'd2, 16'h07FF);
            chk("R3 rx below threshold", 32'(stat_raw[4]), 0);
            rx_fill = CNT_W'(thr);
            step();
            chk("R3 rx at threshold", 32'(stat_raw[4]), 1);
            rx_fill = '0;
            step();
        end
    endtask

    task automatic t_tx_levels();
        for (int c = 0; c < 8; c++) begin
            int thr = exp_thr(c);
            wr(2'd0, 16'(c));
            chk("R2 level tx field", 32'(cfg_level), 32'(c));
            tx_fill = CNT_W'(thr + 1);
            wr(2'd2, 16'h07FF);
            chk("R4 tx above threshold", 32'(stat_raw[5]), 0);
            tx_fill = CNT_W'(thr);
            step();
            chk("R4 tx at threshold", 32'(stat_raw[5]), 1);
            tx_fill = 5'd16;
            step();
        end
        wr(2'd2, 16'h07FF);
    endtask

    task automatic t_sticky();
        rx_fill = 5'd16;
        step();
        rx_fill = '0;
        step();
        step();
        chk("R6 rx bit held", 32'(stat_raw[4]), 1);
        wr(2'd2, 16'h07FF);
        chk("R7 cleared after hold", 32'(stat_raw), 0);
    endtask

    task automatic t_events();
        for (int i = 0; i < 11; i++) begin
            if (i == 4 || i == 5) continue;
            drive_evt(i, 1'b1);
            step();
            drive_evt(i, 1'b0);
            chk("R5 event bit map", 32'(stat_raw), 32'(1) << i);
            wr(2'd2, 16'h07FF);
        end
    endtask

    task automatic t_clear_and_priority();
        fe_pulse = 1'b1; pe_pulse = 1'b1;
        step();
        fe_pulse = 1'b0; pe_pulse = 1'b0;
        wr(2'd2, 16'h0080);
        chk("R7 partial clear", 32'(stat_raw), 32'h100);
        fe_pulse = 1'b1;
        wr(2'd2, 16'h0080);
        fe_pulse = 1'b0;
        chk("R8 set wins over clear", 32'(stat_raw), 32'h180);
        wr(2'd2, 16'h07FF);
        chk("R7 clear without set", 32'(stat_raw), 0);
    endtask

    task automatic t_mask_any();
        fe_pulse = 1'b1; oe_pulse = 1'b1;
        step();
        fe_pulse = 1'b0; oe_pulse = 1'b0;
        chk("R9 nothing masked yet", 32'(irq_masked), 0);
        chk("R10 any low with mask 0", 32'(irq_any), 0);
        wr(2'd1, 16'h00A0);
        chk("R9 mask loaded", 32'(cfg_mask), 32'h0A0);
        chk("R11 raw kept on mask write", 32'(stat_raw), 32'h480);
        chk("R9 masked lines", 32'(irq_masked), 32'h080);
        chk("R10 any lags one clock", 32'(irq_any), 0);
        step();
        chk("R10 any rises", 32'(irq_any), 1);
        wr(2'd2, 16'h0080);
        chk("R9 masked after clear", 32'(irq_masked), 0);
        chk("R10 any still high", 32'(irq_any), 1);
        chk("R7 overrun kept", 32'(stat_raw), 32'h400);
        step();
        chk("R10 any falls", 32'(irq_any), 0);
    endtask

    initial begin
        t_reset();
        t_rx_levels();
        t_tx_levels();
        t_sticky();
        t_events();
        t_clear_and_priority();
        t_mask_any();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule